// File: doc/BRIEF.md
# 8-bit ALU with Protected Status Register

This block is the execution core of a small 8-bit controller datapath. It takes an opcode and two byte operands and produces a byte result in the same cycle, with no register on that path. Carry-in and auxiliary carry for the carry-using operations come from the block's own status register. When an operation is committed with `exec_i`, the carry (C), auxiliary carry (AC), zero (Z) and overflow (OV) flags are written back into the status register on the next rising clock edge. Each operation writes only the flags it owns.

A separate combinational output, `skip_o`, carries the branch decision for the four skip opcodes. It tells the sequencer to skip the next instruction.

The status register also holds a power-down flag (PDF) and a watchdog time-out flag (TO). Software flag writes cannot reach these two bits. They move only on four event inputs: power-on, halt, watchdog overflow and watchdog clear. Instruction decode, the register file and the watchdog counter live outside this block.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 0) gives A+B and ADC (code 1) gives A+B+C, using the stored C. Both write C = carry out of bit 7, AC = carry out of bit 3, Z = (result==0) and OV = signed overflow.
- R2: SUB (code 2) computes A+~B+1 and SBC (code 3) computes A+~B+C. C=1 means no borrow. AC, Z and OV follow the same rules as in R1.
- R3: DAA (code 4) first adds 0x06 when A[3:0]>9 or AC=1. It then adds 0x60 when the upper nibble of that intermediate is above 9, C=1, or the first step carried. The new C is 1 if C was already set or either step carried out. DAA writes only C.
- R4: AND (5), OR (6) and XOR (7) act on A and B, and CPL (8) gives ~A. These four write only Z; C, AC and OV keep their values.
- R5: RL (9) rotates A left and RR (10) rotates A right, with no flag change. RLC (11) gives {A[6:0],C} and RRC (12) gives {C,A[7:1]}. Each of these two loads the bit that falls out (A[7] for RLC, A[0] for RRC) into C and writes no other flag.
- R6: INC (13) gives A+1 and DEC (14) gives A-1, both wrapping modulo 256. Each writes only Z.
- R7: SZ (15) skips when A==0 and SNZ (16) skips when A!=0; both return A. SIZ (17) returns A+1 and skips when that value is 0. SDZ (18) returns A-1 and skips when that value is 0. No skip opcode changes any flag, and `skip_o` is 0 for every other code.
- R8: The status byte has C in bit 0, AC in bit 1, Z in bit 2, OV in bit 3, PDF in bit 4 and TO in bit 5. Bits 7:6 always read 0. Flags change only on a clock edge where `exec_i`, `flag_wr_i` or an event input is high.
- R9: A flag write loads `flag_wr_data_i[3:0]` into status bits 3:0 and takes priority over `exec_i` in the same cycle. It never changes TO or PDF.
- R10: `por_i` clears TO and PDF. Otherwise `wdt_clr_i` clears both. Otherwise `halt_i` sets PDF and `wdt_ovf_i` sets TO, and both may act in the same cycle.
- R11: A synchronous active-high reset clears the whole status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Operand A (accumulator) |
| b_i | input | 8 | Operand B |
| exec_i | input | 1 | Commit the operation's flags at the next edge |
| flag_wr_i | input | 1 | Software write of C/AC/Z/OV |
| flag_wr_data_i | input | 4 | New {OV,Z,AC,C} for a software write |
| por_i | input | 1 | Power-on event |
| halt_i | input | 1 | Halt executed |
| wdt_ovf_i | input | 1 | Watchdog overflow event |
| wdt_clr_i | input | 1 | Watchdog clear event |
| result_o | output | 8 | Combinational result |
| skip_o | output | 1 | Skip decision for skip opcodes |
| status_o | output | 8 | Status register |

## Verification
The assertions check the register rules on every cycle. The reserved bits stay at zero. The flags hold when nothing writes them. TO and PDF survive software writes, and the event inputs set or clear them as R10 describes. Logical operations leave C, AC and OV alone. `skip_o` stays low outside the skip codes, and INC wraps.

The arithmetic values themselves can only be shown by the bench's scenarios. These are the overflow and half-carry corners of add and subtract, borrow sense, both decimal-adjust branches, and the carry path into ADC, SBC, RLC and RRC. The scenarios also cover priority when a flag write, a commit and events fall on the same edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW = 8;
    localparam int NW = DW / 2;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_DAA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
        OP_CPL = 5'd8,  OP_RL  = 5'd9,  OP_RR  = 5'd10, OP_RLC = 5'd11,
        OP_RRC = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_SZ  = 5'd15,
        OP_SNZ = 5'd16, OP_SIZ = 5'd17, OP_SDZ = 5'd18
    } alu_op_e;

    // Which flags an operation owns
    typedef enum logic [1:0] {
        FX_NONE  = 2'd0,
        FX_ALL   = 2'd1,
        FX_CARRY = 2'd2,
        FX_ZERO  = 2'd3
    } flag_fx_e;

    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [1:0] rsv;
        logic       to;
        logic       pdf;
        flags_t     fl;
    } status_t;

    typedef struct packed {
        logic [DW-1:0] value;
        flags_t        fl;
        flag_fx_e      fx;
        logic          skip;
    } alu_out_t;

    function automatic logic is_arith_op(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_DAA,
            OP_INC, OP_DEC, OP_SIZ, OP_SDZ: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic is_skip_op(alu_op_e op);
        return (op == OP_SZ) || (op == OP_SNZ) || (op == OP_SIZ) || (op == OP_SDZ);
    endfunction

    // Nibble-split adder: {carry7, carry3, sum}
    function automatic logic [DW+1:0] nib_add(logic [DW-1:0] x, logic [DW-1:0] y, logic ci);
        logic [NW:0] lo;
        logic [NW:0] hi;
        lo = {1'b0, x[NW-1:0]} + {1'b0, y[NW-1:0]} + {{NW{1'b0}}, ci};
        hi = {1'b0, x[DW-1:NW]} + {1'b0, y[DW-1:NW]} + {{NW{1'b0}}, lo[NW]};
        return {hi[NW], lo[NW], hi[NW-1:0], lo[NW-1:0]};
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          acin,
    output alu_out_t      res
);
    localparam logic [DW:0] LO_FIX = (DW+1)'(6);
    localparam logic [DW:0] HI_FIX = (DW+1)'(96);
    localparam logic [NW-1:0] NIB_MAX = NW'(9);

    logic          do_sub;
    logic          carry_in;
    logic [DW-1:0] opnd;
    logic [DW+1:0] sum_w;
    logic [DW-1:0] sum;
    logic          lo_fix, hi_fix;
    logic [DW:0]   t9, u9;
    logic [DW-1:0] inc_v, dec_v;

    assign do_sub = (op == OP_SUB) || (op == OP_SBC);
    assign opnd   = do_sub ? ~b : b;

    always_comb begin
        case (op)
            OP_ADC, OP_SBC: carry_in = cin;
            OP_SUB:         carry_in = 1'b1;
            default:        carry_in = 1'b0;
        endcase
    end

    assign sum_w = nib_add(a, opnd, carry_in);
    assign sum   = sum_w[DW-1:0];

    // Decimal adjust, two stages
    assign lo_fix = (a[NW-1:0] > NIB_MAX) || acin;
    assign t9     = {1'b0, a} + (lo_fix ? LO_FIX : '0);
    assign hi_fix = (t9[DW-1:NW] > NIB_MAX) || cin || t9[DW];
    assign u9     = {1'b0, t9[DW-1:0]} + (hi_fix ? HI_FIX : '0);

    assign inc_v = a + DW'(1);
    assign dec_v = a - DW'(1);

    always_comb begin
        res.value = '0;
        res.fl    = '0;
        res.fx    = FX_NONE;
        res.skip  = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res.value = sum;
                res.fl.c  = sum_w[DW+1];
                res.fl.ac = sum_w[DW];
                res.fl.z  = (sum == '0);
                res.fl.ov = (a[DW-1] == opnd[DW-1]) && (sum[DW-1] != a[DW-1]);
                res.fx    = FX_ALL;
            end
            OP_DAA: begin
                res.value = u9[DW-1:0];
                res.fl.c  = cin | t9[DW] | u9[DW];
                res.fx    = FX_CARRY;
            end
            OP_INC: begin
                res.value = inc_v;
                res.fl.z  = (inc_v == '0);
                res.fx    = FX_ZERO;
            end
            OP_DEC: begin
                res.value = dec_v;
                res.fl.z  = (dec_v == '0);
                res.fx    = FX_ZERO;
            end
            OP_SIZ: begin
                res.value = inc_v;
                res.skip  = (inc_v == '0);
            end
            OP_SDZ: begin
                res.value = dec_v;
                res.skip  = (dec_v == '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output alu_out_t      res
);
    logic [DW-1:0] lv;

    always_comb begin
        case (op)
            OP_AND:  lv = a & b;
            OP_OR:   lv = a | b;
            OP_XOR:  lv = a ^ b;
            OP_CPL:  lv = ~a;
            default: lv = a;
        endcase
    end

    always_comb begin
        res.value = '0;
        res.fl    = '0;
        res.fx    = FX_NONE;
        res.skip  = 1'b0;
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                res.value = lv;
                res.fl.z  = (lv == '0);
                res.fx    = FX_ZERO;
            end
            OP_RL:  res.value = {a[DW-2:0], a[DW-1]};
            OP_RR:  res.value = {a[0], a[DW-1:1]};
            OP_RLC: begin
                res.value = {a[DW-2:0], cin};
                res.fl.c  = a[DW-1];
                res.fx    = FX_CARRY;
            end
            OP_RRC: begin
                res.value = {cin, a[DW-1:1]};
                res.fl.c  = a[0];
                res.fx    = FX_CARRY;
            end
            OP_SZ: begin
                res.value = a;
                res.skip  = (a == '0);
            end
            OP_SNZ: begin
                res.value = a;
                res.skip  = (a != '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     upd_en,
    input  flag_fx_e fx,
    input  flags_t   fl_new,
    input  logic     wr_en,
    input  flags_t   wr_fl,
    input  logic     por,
    input  logic     halt,
    input  logic     wdt_ovf,
    input  logic     wdt_clr,
    output status_t  st
);
    status_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.fl = wr_fl;
        end else if (upd_en) begin
            case (fx)
                FX_ALL:   st_d.fl   = fl_new;
                FX_CARRY: st_d.fl.c = fl_new.c;
                FX_ZERO:  st_d.fl.z = fl_new.z;
                default:  ;
            endcase
        end
        if (por || wdt_clr) begin
            st_d.to  = 1'b0;
            st_d.pdf = 1'b0;
        end else begin
            if (halt)    st_d.pdf = 1'b1;
            if (wdt_ovf) st_d.to  = 1'b1;
        end
        st_d.rsv = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st = st_q;

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        st_q.rsv == 2'b00);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !wr_en) |=> $stable(st_q.fl));

    assert_write_guard_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !por && !halt && !wdt_ovf && !wdt_clr) |=> ($stable(st_q.to) && $stable(st_q.pdf)));

    assert_por_clear_R10: assert property (@(posedge clk) disable iff (rst)
        por |=> (!st_q.to && !st_q.pdf));

    assert_halt_set_R10: assert property (@(posedge clk) disable iff (rst)
        (halt && !por && !wdt_clr) |=> st_q.pdf);

    assert_logic_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !wr_en && fx == FX_ZERO) |=> ($stable(st_q.fl.c) && $stable(st_q.fl.ac) && $stable(st_q.fl.ov)));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          exec_i,
    input  logic          flag_wr_i,
    input  logic [3:0]    flag_wr_data_i,
    input  logic          por_i,
    input  logic          halt_i,
    input  logic          wdt_ovf_i,
    input  logic          wdt_clr_i,
    output logic [DW-1:0] result_o,
    output logic          skip_o,
    output logic [DW-1:0] status_o
);
    alu_op_e  op;
    alu_out_t arith_res, logic_res, sel_res;
    status_t  st;

    assign op = alu_op_e'(op_i);

    alu8_arith u_arith (
        .op   (op),
        .a    (a_i),
        .b    (b_i),
        .cin  (st.fl.c),
        .acin (st.fl.ac),
        .res  (arith_res)
    );

    alu8_logic u_logic (
        .op   (op),
        .a    (a_i),
        .b    (b_i),
        .cin  (st.fl.c),
        .res  (logic_res)
    );

    assign sel_res = is_arith_op(op) ? arith_res : logic_res;

    alu8_status u_status (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (exec_i),
        .fx      (sel_res.fx),
        .fl_new  (sel_res.fl),
        .wr_en   (flag_wr_i),
        .wr_fl   (flags_t'(flag_wr_data_i)),
        .por     (por_i),
        .halt    (halt_i),
        .wdt_ovf (wdt_ovf_i),
        .wdt_clr (wdt_clr_i),
        .st      (st)
    );

    assign result_o = sel_res.value;
    assign skip_o   = sel_res.skip;
    assign status_o = st;

    assert_skip_only_R7: assert property (@(posedge clk) disable iff (rst)
        !is_skip_op(op) |-> !skip_o);

    assert_inc_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC && a_i == '1) |-> (result_o == '0));

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] op_i;
    logic [7:0] a_i, b_i;
    logic       exec_i, flag_wr_i;
    logic [3:0] flag_wr_data_i;
    logic       por_i, halt_i, wdt_ovf_i, wdt_clr_i;
    logic [7:0] result_o;
    logic       skip_o;
    logic [7:0] status_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] m_st;

    typedef struct {
        logic [7:0] res;
        logic       skip;
        logic [7:0] st;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    alu8_core uut (.*);

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // Reference model: result, skip, flags and which flags the op writes
    task automatic model(input logic [4:0] op, input logic [7:0] a, b, input logic [7:0] st,
                         output logic [7:0] r, output logic sk, output logic [3:0] fl,
                         output int cls);
        int   full, lo, t;
        logic c, ac;
        logic [7:0] bb;
        c = st[0]; ac = st[1];
        r = 8'h00; sk = 1'b0; fl = 4'h0; cls = 0;
        case (op)
            0, 1, 2, 3: begin
                bb   = (op >= 2) ? ~b : b;
                t    = (op == 0) ? 0 : (op == 2) ? 1 : int'(c);
                full = int'(a) + int'(bb) + t;
                lo   = int'(a & 8'h0F) + int'(bb & 8'h0F) + t;
                r    = full[7:0];
                fl[0] = full > 255;
                fl[1] = lo > 15;
                fl[2] = (r == 8'h00);
                fl[3] = ((a ^ r) & (bb ^ r) & 8'h80) != 0;
                cls = 1;
            end
            4: begin
                full = int'(a);
                if ((a & 8'h0F) > 9 || ac) full = full + 6;
                lo = full;
                if (((full >> 4) & 15) > 9 || c || full > 255) full = (full & 255) + 96;
                r = full[7:0];
                fl[0] = c || lo > 255 || full > 255;
                cls = 2;
            end
            5, 6, 7, 8: begin
                r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (op == 7) ? (a ^ b) : ~a;
                fl[2] = (r == 0);
                cls = 3;
            end
            9:  r = {a[6:0], a[7]};
            10: r = {a[0], a[7:1]};
            11: begin r = {a[6:0], c}; fl[0] = a[7]; cls = 2; end
            12: begin r = {c, a[7:1]}; fl[0] = a[0]; cls = 2; end
            13, 14: begin
                r = (op == 13) ? a + 8'd1 : a - 8'd1;
                fl[2] = (r == 0);
                cls = 3;
            end
            15: begin r = a; sk = (a == 0); end
            16: begin r = a; sk = (a != 0); end
            17: begin r = a + 8'd1; sk = (r == 0); end
            18: begin r = a - 8'd1; sk = (r == 0); end
            default: ;
        endcase
    endtask

    task automatic drive(input logic [4:0] op, input logic [7:0] a, b,
                         input logic ex, sw, input logic [3:0] swd,
                         input logic por, hlt, ovf, clr, input string tag);
        logic [7:0] r, nst;
        logic       sk;
        logic [3:0] fl;
        int         cls;
        exp_t       it;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; exec_i = ex; flag_wr_i = sw;
        flag_wr_data_i = swd; por_i = por; halt_i = hlt; wdt_ovf_i = ovf; wdt_clr_i = clr;
        model(op, a, b, m_st, r, sk, fl, cls);
        nst = m_st;
        if (sw) nst[3:0] = swd;
        else if (ex) begin
            if (cls == 1) nst[3:0] = fl;
            if (cls == 2) nst[0] = fl[0];
            if (cls == 3) nst[2] = fl[2];
        end
        if (por || clr) nst[5:4] = 2'b00;
        else begin
            if (hlt) nst[4] = 1'b1;
            if (ovf) nst[5] = 1'b1;
        end
        nst[7:6] = 2'b00;
        it.res = r; it.skip = sk; it.st = nst; it.tag = tag;
        sb_q.push_back(it);
        m_st = nst;
    endtask

    task automatic op1(input logic [4:0] op, input logic [7:0] a, b, input string tag);
        drive(op, a, b, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: pop expected item, compare result before the edge and status after
    initial begin
        exp_t it;
        logic [7:0] r_s;
        logic       k_s;
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it  = sb_q.pop_front();
                r_s = result_o;
                k_s = skip_o;
                @(posedge clk);
                #1;
                check(it.tag, "result", r_s, it.res);
                check(it.tag, "skip", {7'b0, k_s}, {7'b0, it.skip});
                check(it.tag, "status", status_o, it.st);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; op_i = 0; a_i = 0; b_i = 0; exec_i = 0; flag_wr_i = 0;
        flag_wr_data_i = 0; por_i = 0; halt_i = 0; wdt_ovf_i = 0; wdt_clr_i = 0;
        m_st = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "status after reset", status_o, 8'h00);
        rst = 1'b0;

        // R1 add / add with carry
        op1(0, 8'h7F, 8'h01, "R1 add ov");
        op1(0, 8'hFF, 8'h01, "R1 add wrap");
        op1(1, 8'h10, 8'h20, "R1 adc c=1");
        op1(1, 8'hF0, 8'h0F, "R1 adc carry");
        // R2 subtract / borrow
        op1(2, 8'h05, 8'h03, "R2 sub");
        op1(2, 8'h03, 8'h05, "R2 sub borrow");
        op1(3, 8'h10, 8'h01, "R2 sbc c=0");
        op1(2, 8'h80, 8'h01, "R2 sub ov");
        op1(3, 8'h10, 8'h01, "R2 sbc c=1");
        // R3 decimal adjust
        op1(0, 8'h15, 8'h27, "R3 pre");
        op1(4, 8'h3C, 8'h00, "R3 daa low");
        op1(0, 8'h09, 8'h09, "R3 pre ac");
        op1(4, 8'h12, 8'h00, "R3 daa ac");
        op1(0, 8'h00, 8'h00, "R3 clr");
        op1(4, 8'h9A, 8'h00, "R3 daa both");
        // R4 logic with C/AC/OV held
        drive(0, 8'h00, 8'h00, 1'b0, 1'b1, 4'hB, 1'b0, 1'b0, 1'b0, 1'b0, "R9 set flags");
        op1(5, 8'hF0, 8'h0F, "R4 and zero");
        op1(6, 8'h50, 8'h05, "R4 or");
        op1(7, 8'hAA, 8'hAA, "R4 xor");
        op1(8, 8'h0F, 8'h00, "R4 cpl");
        // R5 rotations
        op1(9, 8'h81, 8'h00, "R5 rl");
        op1(10, 8'h81, 8'h00, "R5 rr");
        op1(11, 8'h80, 8'h00, "R5 rlc");
        op1(11, 8'h01, 8'h00, "R5 rlc cin");
        op1(12, 8'h01, 8'h00, "R5 rrc");
        op1(12, 8'h02, 8'h00, "R5 rrc cin");
        // R6 inc / dec
        op1(13, 8'hFF, 8'h00, "R6 inc wrap");
        op1(14, 8'h00, 8'h00, "R6 dec wrap");
        op1(14, 8'h01, 8'h00, "R6 dec zero");
        // R7 skips
        op1(15, 8'h00, 8'h00, "R7 sz hit");
        op1(15, 8'h04, 8'h00, "R7 sz miss");
        op1(16, 8'h04, 8'h00, "R7 snz hit");
        op1(17, 8'hFF, 8'h00, "R7 siz hit");
        op1(17, 8'h10, 8'h00, "R7 siz miss");
        op1(18, 8'h01, 8'h00, "R7 sdz hit");
        op1(18, 8'h00, 8'h00, "R7 sdz miss");
        // R8 no commit: flags hold
        drive(0, 8'hFF, 8'h01, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 no exec");
        // R10 events, R9 write guard
        drive(9, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 halt");
        drive(9, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R10 wdt ovf");
        drive(0, 8'h01, 8'h01, 1'b1, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0, "R9 write over exec");
        drive(9, 8'h00, 8'h00, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 write keeps TO PDF");
        drive(9, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 wdt clr");
        drive(9, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, "R10 halt+ovf");
        drive(9, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, "R10 clr wins");
        drive(9, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, "R10 set again");
        drive(9, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, "R10 por");
        @(negedge clk);
        exec_i = 0; flag_wr_i = 0; por_i = 0; halt_i = 0; wdt_ovf_i = 0; wdt_clr_i = 0;
        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule